// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Block Memory

This block is an 18-kilobit synchronous memory reached through two ports, A and B. Each port has its own clock, enable, write enable, synchronous output clear, address, write data and registered read data. Each port has its own word width, chosen by a parameter. One port can therefore store narrow words while the other reads the same bits back as wide words. This makes the block a width converter as well as a store. Words of 9, 18 and 36 bits carry one parity bit per data byte, and those parity bits are kept in the same array.

The storage is organised as rows of 32 data bits plus 4 parity bits. A port of width W holds K = 32/D words per row, where D is the number of data bits in W. Narrow address `a` selects row `a / K` and lane `a % K`. The lowest narrow address sits in the least significant data bits of the row. Each port presents its read data one clock after the access, on its own clock.

Top module: `asym_tdp_ram`

## Requirements
- R1: `A_WIDTH` and `B_WIDTH` each take one of 1, 2, 4, 9, 18 or 36. A port of width W has D data bits (W for 1/2/4, else 8·W/9) and P parity bits (0 for 1/2/4, else W/9). Its depth is `ROWS`·32/D and every address in that range reaches distinct bits.
- R2: Narrow address `a` maps to row `a/K`, data bits `[(a%K)·D +: D]` and parity bits `[32 + (a%K)·P +: P]` of the 36-bit row, where K = 32/D. Within a port word, data occupies bits `[D-1:0]` and parity occupies bits `[W-1:D]`.
- R3: A read (enable high, write enable low, clear low) presents the stored word on that port's data output after the next rising edge of that port's clock.
- R4: A write (enable and write enable high) stores the word, and after the same edge the data output shows the word just written (write-first).
- R5: With enable low, nothing is written and the port's data output holds its value.
- R6: With enable and the synchronous clear high, the data output becomes zero after the edge; a write requested in the same cycle is still performed.
- R7: Driving `rst_ni` low clears both data outputs at once, without a clock edge, and leaves the stored contents unchanged.
- R8: A write from a port of width 1, 2 or 4 changes no parity bit; parity bits written through a wide port read back unchanged afterwards.
- R9: Accesses from the two ports in the same cycle to disjoint bits all take effect. A port reading bits that the other port writes at the same edge returns the contents from before that write. Writes from both ports to overlapping bits at the same edge leave those bits undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low clear of both output registers |
| clk_a_i | input | 1 | Port A clock |
| en_a_i | input | 1 | Port A access enable |
| we_a_i | input | 1 | Port A write enable |
| srst_a_i | input | 1 | Port A synchronous output clear |
| addr_a_i | input | log2(ROWS·32/D_A) | Port A word address |
| din_a_i | input | A_WIDTH | Port A write data |
| dout_a_o | output | A_WIDTH | Port A registered read data |
| clk_b_i | input | 1 | Port B clock |
| en_b_i | input | 1 | Port B access enable |
| we_b_i | input | 1 | Port B write enable |
| srst_b_i | input | 1 | Port B synchronous output clear |
| addr_b_i | input | log2(ROWS·32/D_B) | Port B word address |
| din_b_i | input | B_WIDTH | Port B write data |
| dout_b_o | output | B_WIDTH | Port B registered read data |

## Verification
The hardest case to reach is the one where both ports touch the same row at one clock edge. The port that reads must see the old bits while the other port's write lands, and two writes to disjoint lanes of one row must not disturb each other. The bench drives both ports from one clock so these collisions fall on a known edge. It schedules a narrow write into a lane of a row that the wide port is reading in the same cycle. It also pairs a wide write with a narrow read of a lane inside it, and disjoint writes from both ports in one cycle. Each result is then compared against a reference array. Full sweeps write through one width and read back through the other, which covers the lane mapping and the survival of parity bits.

// File: rtl/atdp_pkg.sv
package atdp_pkg;
  localparam int unsigned ROW_DATA = 32;
  localparam int unsigned ROW_PAR  = 4;
  localparam int unsigned ROW_W    = ROW_DATA + ROW_PAR;

  function automatic int unsigned data_bits(int unsigned w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int unsigned par_bits(int unsigned w);
    return (w >= 9) ? w / 9 : 0;
  endfunction

  function automatic int unsigned addr_bits(int unsigned w, int unsigned rows);
    return $clog2(rows * (ROW_DATA / data_bits(w)));
  endfunction
endpackage

// File: rtl/atdp_lane_map.sv
module atdp_lane_map
  import atdp_pkg::*;
#(
  parameter int unsigned W    = 36,
  parameter int unsigned ROWS = 512,
  localparam int unsigned D   = data_bits(W),
  localparam int unsigned P   = par_bits(W),
  localparam int unsigned K   = ROW_DATA / D,
  localparam int unsigned LB  = $clog2(K),
  localparam int unsigned RW  = $clog2(ROWS),
  localparam int unsigned AW  = RW + LB
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     din_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [RW-1:0]    row_idx_o,
  output logic [ROW_W-1:0] wmask_o,
  output logic [ROW_W-1:0] wval_o,
  output logic [W-1:0]     rd_o
);
  int unsigned lane, doff, poff;
  logic [ROW_W-1:0] dmask_lo, pmask_lo, din_pad, rd_pad;

  always_comb begin
    row_idx_o = addr_i[AW-1:LB];
    lane      = 32'(addr_i) % K;
    doff      = lane * D;
    poff      = ROW_DATA + lane * P;
    dmask_lo  = (ROW_W'(1) << D) - ROW_W'(1);
    pmask_lo  = (ROW_W'(1) << P) - ROW_W'(1);
    din_pad   = ROW_W'(din_i);
    // data in low D bits of the word, parity above it
    wmask_o   = (dmask_lo << doff) | (pmask_lo << poff);
    wval_o    = ((din_pad & dmask_lo) << doff) | (((din_pad >> D) & pmask_lo) << poff);
    rd_pad    = ((row_i >> doff) & dmask_lo) | (((row_i >> poff) & pmask_lo) << D);
    rd_o      = rd_pad[W-1:0];
  end
endmodule

// File: rtl/atdp_port.sv
module atdp_port
  import atdp_pkg::*;
#(
  parameter int unsigned W    = 36,
  parameter int unsigned ROWS = 512,
  localparam int unsigned RW  = $clog2(ROWS),
  localparam int unsigned AW  = addr_bits(W, ROWS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       we_i,
  input  logic                       srst_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [W-1:0]               din_i,
  output logic [W-1:0]               dout_o,
  input  logic [ROWS-1:0][ROW_W-1:0] peer_bank_i,
  output logic [ROWS-1:0][ROW_W-1:0] bank_o
);
  // stored value = own bank XOR peer bank; each bank has a single writer
  logic [ROWS-1:0][ROW_W-1:0] bank_q;
  logic [RW-1:0]    row_idx;
  logic [ROW_W-1:0] wmask, wval, cur_row;
  logic [W-1:0]     rd_word, dout_q;

  assign cur_row = bank_q[row_idx] ^ peer_bank_i[row_idx];

  atdp_lane_map #(.W(W), .ROWS(ROWS)) u_map (
    .addr_i    (addr_i),
    .din_i     (din_i),
    .row_i     (cur_row),
    .row_idx_o (row_idx),
    .wmask_o   (wmask),
    .wval_o    (wval),
    .rd_o      (rd_word)
  );

  always_ff @(posedge clk_i) begin
    if (en_i && we_i)
      bank_q[row_idx] <= (bank_q[row_idx] & ~wmask) | ((wval ^ peer_bank_i[row_idx]) & wmask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dout_q <= '0;
    else if (en_i) begin
      if (srst_i)       dout_q <= '0;
      else if (we_i)    dout_q <= din_i;
      else              dout_q <= rd_word;
    end
  end

  assign bank_o = bank_q;
  assign dout_o = dout_q;

  p_write_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && we_i && !srst_i |=> dout_o == $past(din_i));
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dout_o));
  p_bank_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && we_i) |=> bank_o == $past(bank_o));
  p_srst_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && srst_i |=> dout_o == '0);

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_clear_r7: assert (dout_o == '0);
  end
endmodule

// File: rtl/asym_tdp_ram.sv
module asym_tdp_ram
  import atdp_pkg::*;
#(
  parameter int unsigned ROWS    = 512,
  parameter int unsigned A_WIDTH = 4,
  parameter int unsigned B_WIDTH = 36,
  localparam int unsigned AW_A   = addr_bits(A_WIDTH, ROWS),
  localparam int unsigned AW_B   = addr_bits(B_WIDTH, ROWS)
) (
  input  logic               rst_ni,
  input  logic               clk_a_i,
  input  logic               en_a_i,
  input  logic               we_a_i,
  input  logic               srst_a_i,
  input  logic [AW_A-1:0]    addr_a_i,
  input  logic [A_WIDTH-1:0] din_a_i,
  output logic [A_WIDTH-1:0] dout_a_o,
  input  logic               clk_b_i,
  input  logic               en_b_i,
  input  logic               we_b_i,
  input  logic               srst_b_i,
  input  logic [AW_B-1:0]    addr_b_i,
  input  logic [B_WIDTH-1:0] din_b_i,
  output logic [B_WIDTH-1:0] dout_b_o
);
  logic [ROWS-1:0][ROW_W-1:0] bank_a, bank_b;

  atdp_port #(.W(A_WIDTH), .ROWS(ROWS)) u_port_a (
    .clk_i       (clk_a_i),
    .rst_ni      (rst_ni),
    .en_i        (en_a_i),
    .we_i        (we_a_i),
    .srst_i      (srst_a_i),
    .addr_i      (addr_a_i),
    .din_i       (din_a_i),
    .dout_o      (dout_a_o),
    .peer_bank_i (bank_b),
    .bank_o      (bank_a)
  );

  atdp_port #(.W(B_WIDTH), .ROWS(ROWS)) u_port_b (
    .clk_i       (clk_b_i),
    .rst_ni      (rst_ni),
    .en_i        (en_b_i),
    .we_i        (we_b_i),
    .srst_i      (srst_b_i),
    .addr_i      (addr_b_i),
    .din_i       (din_b_i),
    .dout_o      (dout_b_o),
    .peer_bank_i (bank_a),
    .bank_o      (bank_b)
  );
endmodule

// File: tb/asym_tdp_ram_test.sv
module asym_tdp_ram_test;
  localparam int ROWS = 16;
  localparam int AA = 7;
  localparam int AB = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni;
  logic en_a, we_a, srst_a, en_b, we_b, srst_b;
  logic [AA-1:0] addr_a;
  logic [AB-1:0] addr_b;
  logic [3:0]  din_a, dout_a;
  logic [35:0] din_b, dout_b;

  asym_tdp_ram #(.ROWS(ROWS), .A_WIDTH(4), .B_WIDTH(36)) uut (
    .rst_ni(rst_ni),
    .clk_a_i(clk), .en_a_i(en_a), .we_a_i(we_a), .srst_a_i(srst_a),
    .addr_a_i(addr_a), .din_a_i(din_a), .dout_a_o(dout_a),
    .clk_b_i(clk), .en_b_i(en_b), .we_b_i(we_b), .srst_b_i(srst_b),
    .addr_b_i(addr_b), .din_b_i(din_b), .dout_b_o(dout_b)
  );

  int vectors = 0;
  int errs = 0;
  logic [35:0] ref_mem [ROWS];

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  function automatic logic [35:0] pat_b(int r);
    return {4'(r * 3 + 1), 32'(r * 32'h01234567) ^ 32'hC3A55A3C};
  endfunction

  function automatic logic [3:0] pat_a(int a);
    return 4'(a * 7 + 3);
  endfunction

  function automatic logic [3:0] ref_nib(int a);
    return ref_mem[a / 8][(a % 8) * 4 +: 4];
  endfunction

  task automatic idle();
    en_a = 0; we_a = 0; srst_a = 0; en_b = 0; we_b = 0; srst_b = 0;
  endtask

  task automatic a_op(bit we, bit sr, int addr, logic [3:0] d);
    en_a = 1; we_a = we; srst_a = sr; addr_a = AA'(addr); din_a = d;
    @(negedge clk);
    idle();
  endtask

  task automatic b_op(bit we, bit sr, int row, logic [35:0] d);
    en_b = 1; we_b = we; srst_b = sr; addr_b = AB'(row); din_b = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [3:0] held;
    rst_ni = 0; idle(); addr_a = '0; addr_b = '0; din_a = '0; din_b = '0;
    repeat (2) @(negedge clk);
    chk("R7 reset A", 36'(dout_a), 36'h0);
    chk("R7 reset B", dout_b, 36'h0);
    rst_ni = 1;
    @(negedge clk);

    // wide fill, write-first
    for (int r = 0; r < ROWS; r++) begin
      b_op(1, 0, r, pat_b(r));
      ref_mem[r] = pat_b(r);
      chk("R4 wide write-first", dout_b, pat_b(r));
    end
    // narrow read of every lane: R1 R2 R3
    for (int a = 0; a < ROWS * 8; a++) begin
      a_op(0, 0, a, 4'h0);
      chk("R2 R3 narrow read", 36'(dout_a), 36'(ref_nib(a)));
    end
    // narrow write of every address: R1 R4
    for (int a = 0; a < ROWS * 8; a++) begin
      a_op(1, 0, a, pat_a(a));
      ref_mem[a / 8][(a % 8) * 4 +: 4] = pat_a(a);
      chk("R4 narrow write-first", 36'(dout_a), 36'(pat_a(a)));
    end
    // wide readback: mapping R1 R2, parity untouched R8
    for (int r = 0; r < ROWS; r++) begin
      b_op(0, 0, r, 36'h0);
      chk("R8 R2 wide readback", dout_b, ref_mem[r]);
    end

    // R5: disabled write is ignored, output holds
    a_op(0, 0, 5, 4'h0);
    held = dout_a;
    en_a = 0; we_a = 1; addr_a = AA'(5); din_a = ~held;
    @(negedge clk);
    chk("R5 hold", 36'(dout_a), 36'(held));
    idle();
    a_op(0, 0, 5, 4'h0);
    chk("R5 no write", 36'(dout_a), 36'(ref_nib(5)));

    // R6: sync clear with write
    a_op(1, 1, 9, 4'hE);
    ref_mem[1][4 +: 4] = 4'hE;
    chk("R6 clear", 36'(dout_a), 36'h0);
    a_op(0, 0, 9, 4'h0);
    chk("R6 write kept", 36'(dout_a), 36'hE);
    b_op(0, 1, 2, 36'h0);
    chk("R6 wide clear", dout_b, 36'h0);

    // R9: narrow write into row read by wide port in same cycle
    en_a = 1; we_a = 1; addr_a = AA'(5 * 8 + 3); din_a = ~ref_nib(43);
    en_b = 1; we_b = 0; addr_b = AB'(5);
    @(negedge clk);
    chk("R9 wide sees old", dout_b, ref_mem[5]);
    ref_mem[5][12 +: 4] = din_a;
    idle();
    b_op(0, 0, 5, 36'h0);
    chk("R9 wide sees new", dout_b, ref_mem[5]);

    // R9: wide write while narrow reads a lane inside it
    en_a = 1; we_a = 0; addr_a = AA'(7 * 8 + 1);
    en_b = 1; we_b = 1; addr_b = AB'(7); din_b = 36'hA_5A5A_F00F;
    @(negedge clk);
    chk("R9 narrow sees old", 36'(dout_a), 36'(ref_nib(57)));
    ref_mem[7] = 36'hA_5A5A_F00F;
    idle();
    a_op(0, 0, 57, 4'h0);
    chk("R9 narrow sees new", 36'(dout_a), 36'(ref_nib(57)));

    // R9: disjoint writes from both ports, same edge
    en_a = 1; we_a = 1; addr_a = AA'(2 * 8); din_a = 4'h1;
    en_b = 1; we_b = 1; addr_b = AB'(11); din_b = 36'h3_1234_ABCD;
    @(negedge clk);
    ref_mem[2][3:0] = 4'h1;
    ref_mem[11] = 36'h3_1234_ABCD;
    idle();
    a_op(0, 0, 16, 4'h0);
    chk("R9 disjoint A", 36'(dout_a), 36'h1);
    b_op(0, 0, 11, 36'h0);
    chk("R9 disjoint B", dout_b, ref_mem[11]);
    b_op(0, 0, 2, 36'h0);
    chk("R9 row neighbour", dout_b, ref_mem[2]);

    // R7: async clear mid-run, contents kept
    a_op(0, 0, 3, 4'h0);
    b_op(0, 0, 4, 36'h0);
    rst_ni = 0;
    #1;
    chk("R7 async A", 36'(dout_a), 36'h0);
    chk("R7 async B", dout_b, 36'h0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    b_op(0, 0, 3, 36'h0);
    chk("R7 contents kept", dout_b, ref_mem[3]);

    finish_run();
  end
endmodule